// File: doc/BRIEF.md
# Per-CPU Device Interrupt Masking Unit

This block sits between the device interrupt sources of a small multiprocessor and the CPUs. The sources drive a 64-bit raw request vector, one bit per source. Each CPU owns a 64-bit enable mask. The block keeps a filtered copy of the requests for each CPU: that CPU's mask ANDed with the raw vector. It raises one interrupt line per CPU while that CPU's filtered copy has any bit set.

Software reaches the masks, the filtered copies and the raw vector through a simple register port. An access gives an address offset, a size code, a write flag and 64-bit write data. The register index is the offset shifted right by six. Read data and an error flag come back one cycle after the access. Only full 64-bit accesses are legal. Only the masks can be written.

Top module: `dev_irq_mask_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all masks are zero, every `cpu_irq` bit is low, `acc_err` is low and `acc_rdata` is zero.
- R2: The register index is `acc_addr >> 6`, and address bits [5:0] are ignored. Index n with n < NUM_CPU is CPU n's mask. Index NUM_CPU+n is CPU n's filtered request. Index 2*NUM_CPU is the raw request vector.
- R3: A legal write to a mask index stores `acc_wdata`. A later read of that index returns the stored value.
- R4: Reading a filtered-request index returns that CPU's mask ANDed with the raw request vector, as both stood before the read.
- R5: After a mask write that sets a bit whose source is requesting, that CPU's `cpu_irq` bit is high in the next cycle.
- R6: After a mask write that clears the last enabled requesting bit, that CPU's `cpu_irq` bit is low in the next cycle.
- R7: A change of `dev_req` reaches the filtered requests and `cpu_irq` one cycle later, with no mask write.
- R8: An access with `acc_size` other than 3 (the 64-bit code) raises `acc_err` for one cycle and changes no mask.
- R9: A write to a filtered-request index or to the raw-request index raises `acc_err` and changes no mask.
- R10: A read or write to any index above 2*NUM_CPU raises `acc_err`.
- R11: `acc_rdata` and `acc_err` are registered and describe the access of the previous cycle. When that cycle had no legal read, `acc_rdata` is zero. When that cycle had no access, `acc_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req | input | 64 | Raw device request vector |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset from block base |
| acc_size | input | 2 | Access size code, 3 = 64-bit |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data, one cycle after the access |
| acc_err | output | 1 | Error pulse, one cycle after a bad access |
| cpu_irq | output | 4 | Device interrupt line per CPU |

## Verification
The request vector is stepped through several patterns while the masks are held constant: a single low bit, bit 63, a pattern that overlaps some masks and not others, and zero. These patterns separate a per-bit AND from a whole-word test and catch crossed CPU lanes. Mask writes are made with the requests both present and absent, which tells a raised interrupt apart from a withdrawn one. Illegal sizes, read-only targets and unmapped indices are each followed by a read-back of the mask the access could have disturbed. A mask write with nonzero low address bits shows that the index decode looks only at bits above bit 5.

// File: rtl/dev_irq_pkg.sv
// Shared types and encodings for the device interrupt masking unit.
// Assumes: a single 64-bit access size code, every other code illegal.
package dev_irq_pkg;
    // Register kinds after index decode.
    typedef enum logic [1:0] {
        KIND_MASK     = 2'd0,
        KIND_FILTERED = 2'd1,
        KIND_RAW      = 2'd2,
        KIND_NONE     = 2'd3
    } reg_kind_e;

    // Access size codes; only the full-width code is accepted.
    localparam logic [1:0] SIZE_FULL = 2'd3;
    // Byte offset to register index shift.
    localparam int REG_SHIFT = 6;
endpackage

// File: rtl/req_capture.sv
// Raw request register: samples the device request vector every cycle.
// Assumes: dev_req is synchronous to clk.
module req_capture #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] dev_req,
    output logic [DATA_W-1:0] req_q
);
    // Capture the raw vector; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= dev_req;
    end
endmodule

// File: rtl/access_decode.sv
// Decodes one register access into a mask write strobe, a read selection
// and an error flag. Assumes the index is the address shifted by REG_SHIFT.
module access_decode
    import dev_irq_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [1:0]            acc_size,
    output logic [NUM_CPU-1:0]    mask_we,
    output logic                  rd_en,
    output reg_kind_e             rd_kind,
    output logic [$clog2(NUM_CPU > 1 ? NUM_CPU : 2)-1:0] rd_sel,
    output logic                  bad
);
    localparam int CPU_W = $clog2(NUM_CPU > 1 ? NUM_CPU : 2);
    localparam int IDX_W = ADDR_W - REG_SHIFT;

    logic [31:0]     idx_u;
    logic [31:0]     filt_off;
    logic            size_ok;
    reg_kind_e       kind;
    logic [CPU_W-1:0] sel;
    logic [REG_SHIFT-1:0] addr_low_unused;

    assign addr_low_unused = acc_addr[REG_SHIFT-1:0];
    assign idx_u    = {{(32-IDX_W){1'b0}}, acc_addr[ADDR_W-1:REG_SHIFT]};
    assign filt_off = idx_u - 32'(NUM_CPU);
    assign size_ok  = (acc_size == SIZE_FULL);

    // Classify the index into a register kind and a CPU number.
    always_comb begin
        kind = KIND_NONE;
        sel  = '0;
        if (idx_u < 32'(NUM_CPU)) begin
            kind = KIND_MASK;
            sel  = idx_u[CPU_W-1:0];
        end else if (idx_u < 32'(2*NUM_CPU)) begin
            kind = KIND_FILTERED;
            sel  = filt_off[CPU_W-1:0];
        end else if (idx_u == 32'(2*NUM_CPU)) begin
            kind = KIND_RAW;
        end
    end

    // Resolve legality, write strobes and read enable.
    always_comb begin
        mask_we = '0;
        rd_en   = 1'b0;
        bad     = 1'b0;
        if (acc_valid) begin
            if (!size_ok || kind == KIND_NONE) begin
                bad = 1'b1;
            end else if (acc_write) begin
                if (kind == KIND_MASK) mask_we[sel] = 1'b1;
                else                   bad = 1'b1;
            end else begin
                rd_en = 1'b1;
            end
        end
    end

    assign rd_kind = kind;
    assign rd_sel  = sel;

    AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_we)); // R2
    AST_NO_WE_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !size_ok) |-> (mask_we == '0)); // R8
endmodule

// File: rtl/mask_bank.sv
// Per-CPU mask registers and filtered request registers, with one interrupt
// line per CPU. The filtered copy is built from the next mask and the
// incoming raw vector so it always matches the registered pair.
module mask_bank #(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_CPU-1:0]               mask_we,
    input  logic [DATA_W-1:0]                wdata,
    input  logic [DATA_W-1:0]                dev_req,
    output logic [NUM_CPU-1:0][DATA_W-1:0]   mask_q,
    output logic [NUM_CPU-1:0][DATA_W-1:0]   filt_q,
    output logic [NUM_CPU-1:0]               irq
);
    for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
        logic [DATA_W-1:0] mask_nxt;

        // Select the value the mask holds after this edge.
        assign mask_nxt = mask_we[g] ? wdata : mask_q[g];

        // Hold the mask and the filtered request for this CPU.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[g] <= '0;
                filt_q[g] <= '0;
            end else begin
                mask_q[g] <= mask_nxt;
                filt_q[g] <= mask_nxt & dev_req;
            end
        end

        // Interrupt line: any enabled request pending.
        assign irq[g] = |filt_q[g];

        AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_we[g] && |(wdata & dev_req)) |=> irq[g]); // R5
        AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_we[g] && wdata == '0) |=> !irq[g]); // R6
        AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !mask_we[g] |=> $stable(mask_q[g])); // R9
    end
endmodule

// File: rtl/dev_irq_mask_unit.sv
// Top of the device interrupt masking unit. Joins the raw request capture,
// the access decoder and the per-CPU mask bank, and registers the read data
// and error flag. Assumes one access per cycle, answered the next cycle.
module dev_irq_mask_unit
    import dev_irq_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  dev_req,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [1:0]         acc_size,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic [DATA_W-1:0]  acc_rdata,
    output logic               acc_err,
    output logic [NUM_CPU-1:0] cpu_irq
);
    localparam int CPU_W = $clog2(NUM_CPU > 1 ? NUM_CPU : 2);

    logic [DATA_W-1:0]              req_q;
    logic [NUM_CPU-1:0]             mask_we;
    logic                           rd_en;
    reg_kind_e                      rd_kind;
    logic [CPU_W-1:0]               rd_sel;
    logic                           bad;
    logic [NUM_CPU-1:0][DATA_W-1:0] mask_q;
    logic [NUM_CPU-1:0][DATA_W-1:0] filt_q;
    logic [DATA_W-1:0]              rd_mux;

    req_capture #(.DATA_W(DATA_W)) u_req (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .req_q(req_q)
    );

    access_decode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .mask_we(mask_we),
        .rd_en(rd_en), .rd_kind(rd_kind), .rd_sel(rd_sel), .bad(bad)
    );

    mask_bank #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .wdata(acc_wdata),
        .dev_req(dev_req), .mask_q(mask_q), .filt_q(filt_q), .irq(cpu_irq)
    );

    // Pick the register named by the decoded read.
    always_comb begin
        case (rd_kind)
            KIND_MASK:     rd_mux = mask_q[rd_sel];
            KIND_FILTERED: rd_mux = filt_q[rd_sel];
            KIND_RAW:      rd_mux = req_q;
            default:       rd_mux = '0;
        endcase
    end

    // Register the response to the current access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rdata <= '0;
            acc_err   <= 1'b0;
        end else begin
            acc_rdata <= rd_en ? rd_mux : '0;
            acc_err   <= bad;
        end
    end

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_chk
        AST_FILT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
            filt_q[g] == (mask_q[g] & req_q)); // R4
    end

    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(acc_valid)); // R11
    AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_size != SIZE_FULL) |=> acc_err); // R8
    AST_RO_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr[ADDR_W-1:REG_SHIFT] >= (ADDR_W-REG_SHIFT)'(NUM_CPU))
        |=> acc_err); // R9
endmodule

// File: tb/tb_dev_irq_mask_unit.sv
`timescale 1ns/1ps
module tb_dev_irq_mask_unit;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] dev_req = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [1:0]  acc_size = 2'd3;
    logic [63:0] acc_wdata = '0;
    logic [63:0] acc_rdata;
    logic        acc_err;
    logic [NC-1:0] cpu_irq;

    int total = 0;
    int bad_n = 0;
    string cur_req = "R1";
    bit done = 0;

    // Reference model state
    logic [63:0] m_mask [NC];
    logic [63:0] m_raw;
    logic [63:0] e_rdata;
    logic        e_err;
    logic [NC-1:0] e_irq;

    always #2.5 clk = ~clk;

    dev_irq_mask_unit dut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_err(acc_err),
        .cpu_irq(cpu_irq)
    );

    // Advance the model by one edge using the inputs present at that edge.
    task automatic model_edge();
        int idx;
        logic [63:0] rd;
        logic er;
        rd = '0; er = 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < NC; i++) m_mask[i] = '0;
            m_raw = '0;
        end else begin
            if (acc_valid) begin
                idx = int'(acc_addr >> 6);
                if (acc_size != 2'd3 || idx > 2*NC) er = 1'b1;
                else if (acc_write) begin
                    if (idx < NC) m_mask[idx] = acc_wdata;
                    else er = 1'b1;
                end else begin
                    if (idx < NC) rd = m_mask[idx];
                    else if (idx < 2*NC) rd = m_mask[idx-NC] & m_raw;
                    else rd = m_raw;
                end
            end
            m_raw = dev_req;
        end
        e_rdata = rd; e_err = er;
        for (int i = 0; i < NC; i++) e_irq[i] = (m_mask[i] & m_raw) != '0;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        total++;
        if (acc_rdata !== e_rdata || acc_err !== e_err || cpu_irq !== e_irq) begin
            bad_n++;
            $display("FAIL %s: rdata=%h err=%b irq=%b expected rdata=%h err=%b irq=%b",
                     cur_req, acc_rdata, acc_err, cpu_irq, e_rdata, e_err, e_irq);
        end
    endtask

    task automatic access(input bit wr, input int idx, input logic [5:0] low,
                          input logic [1:0] sz, input logic [63:0] d);
        acc_valid = 1'b1; acc_write = wr;
        acc_addr  = 12'((idx << 6) | int'(low));
        acc_size  = sz; acc_wdata = d;
        step();
        acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0; acc_size = 2'd3;
    endtask

    initial begin
        #300000;
        bad_n++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad_n);
        $finish;
    end

    initial begin
        // R1: reset state, held then released
        cur_req = "R1";
        step(); step();
        rst_n = 1'b1;
        step();

        // R3: mask write and read back
        cur_req = "R3";
        access(1, 0, 6'd0, 2'd3, 64'h0000_0000_0000_00FF);
        access(0, 0, 6'd0, 2'd3, '0);
        step();

        // R7: request change reaches the irq with no mask write
        cur_req = "R7";
        dev_req = 64'h10; step(); step();
        // R4: filtered and raw reads
        cur_req = "R4";
        access(0, NC+0, 6'd0, 2'd3, '0);
        access(0, 2*NC, 6'd0, 2'd3, '0);

        // R5: mask write enabling a requesting bit
        cur_req = "R5";
        access(1, 1, 6'd0, 2'd3, 64'h10);
        step();
        // R6: mask write clearing it
        cur_req = "R6";
        access(1, 1, 6'd0, 2'd3, 64'h0);
        step();

        // R2: low address bits ignored, index from bits above 5
        cur_req = "R2";
        access(1, 3, 6'h28, 2'd3, 64'h8000_0000_0000_0000);
        access(0, 3, 6'h3F, 2'd3, '0);
        cur_req = "R7";
        dev_req = 64'h8000_0000_0000_0001; step(); step();
        access(0, NC+3, 6'd0, 2'd3, '0);
        dev_req = 64'hFFFF_FFFF_FFFF_FFFF; step();
        access(1, 2, 6'd0, 2'd3, 64'h0F0F_0000_0000_0000);
        access(0, NC+2, 6'd0, 2'd3, '0);

        // R8: narrow access sizes
        cur_req = "R8";
        for (int s = 0; s < 3; s++) begin
            access(1, 2, 6'd0, 2'(s), 64'h0);
            access(0, 2, 6'd0, 2'(s), '0);
        end
        access(0, 2, 6'd0, 2'd3, '0);

        // R9: writes to read-only registers
        cur_req = "R9";
        access(1, NC+2, 6'd0, 2'd3, 64'h0);
        access(1, 2*NC, 6'd0, 2'd3, 64'h0);
        access(0, NC+2, 6'd0, 2'd3, '0);
        access(0, 2, 6'd0, 2'd3, '0);

        // R10: unmapped indices
        cur_req = "R10";
        access(0, 2*NC+1, 6'd0, 2'd3, '0);
        access(1, 40, 6'd0, 2'd3, 64'hFF);
        access(0, 63, 6'd0, 2'd3, '0);

        // R11: idle cycles give zero data and no error
        cur_req = "R11";
        step(); step();
        access(1, 0, 6'd0, 2'd3, 64'h0);
        step();

        // R6 / R7: requests fall away
        cur_req = "R6";
        dev_req = '0; step(); step();
        for (int i = 0; i < NC; i++) access(0, NC+i, 6'd0, 2'd3, '0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad_n);
        $finish;
    end
endmodule